// File: doc/BRIEF.md
# Bridge Reset Control Register

This block is a small register slave that sits in a reset controller. It drives one active-high reset line for each of three bus bridges. The three bridges are a processor-to-fabric bridge, a lightweight processor-to-fabric bridge and a fabric-to-processor bridge. Software holds a bridge in reset by writing 1 to its bit in the control register. It releases the bridge by writing 0.

A second register holds one warm-reset enable bit per bridge. A cold reset, taken asynchronously, puts every control bit back to 1 so that all bridges power up held in reset. A warm reset, taken synchronously, puts back only the control bits whose enable bit is set. The other control bits keep their value.

Reset sequencing and pulse width are left to software. So is the protection against resetting the processor that runs the software.

Top module: `bridge_rst_ctl`

## Requirements
- R1: While cold reset is low, and right after it is released, `bridge_rst` is 3'b111. A read of the control register (byte offset 0x1C) returns 7, and a read of the warm-enable register (offset 0x20) returns 7.
- R2: A write to offset 0x1C without warm reset loads `wdata[2:0]` into `bridge_rst` at the next clock edge. Bit 0 is the processor-to-fabric bridge, bit 1 is the lightweight processor-to-fabric bridge and bit 2 is the fabric-to-processor bridge. A value of 1 asserts the reset and 0 releases it.
- R3: A read with `rd_en` high returns the register contents in `rdata` one clock later. In a cycle after `rd_en` was low, `rdata` is zero.
- R4: When `warm_rst` is high at a clock edge, each control bit whose warm-enable bit (same bit position at offset 0x20) is 1 becomes 1. Each control bit whose enable bit is 0 keeps its value.
- R5: The warm-enable register resets to 7 on cold reset only. A warm reset leaves it unchanged. A write to it in a warm-reset cycle still takes effect.
- R6: The control register keeps its value when there is neither a warm reset nor a write to 0x1C. A write to 0x1C in a cycle with `warm_rst` high is dropped.
- R7: Bits 31 to 3 of both registers read as zero, and writing ones to them has no effect.
- R8: Offsets other than 0x1C and 0x20 read as zero, and writes to them change nothing.
- R9: A low `cold_rst_n` takes effect at once and overrides a warm reset and a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| addr | input | 8 | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| bridge_rst | output | 3 | Bridge reset lines, active high |

## Verification
Reset outputs and warm-enable changes are due at the first clock edge after the write or warm pulse. Read data is due one edge after `rd_en`. Cold reset acts without waiting for an edge. The bench drives every input on the falling edge and moves its reference model on the rising edge. It compares `bridge_rst` and `rdata` 2 ns after each rising edge, so every result is checked in the cycle it is due and never a cycle late. The no-effect cases are checked by reading the registers back through the bus in the next step.

// File: rtl/bridge_rst_ctl.sv
module bridge_rst_ctl #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_BR   = 3,
  parameter int unsigned CTL_OFS  = 'h1C,
  parameter int unsigned MASK_OFS = 'h20
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_BR-1:0] bridge_rst
);

  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

  logic [NUM_BR-1:0] ctl_q, mask_q;
  logic hit_ctl, hit_mask;

  assign hit_ctl    = (addr == CTL_A);
  assign hit_mask   = (addr == MASK_A);
  assign bridge_rst = ctl_q;

  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n)             ctl_q <= '1;
    else if (warm_rst)           ctl_q <= ctl_q | mask_q;
    else if (wr_en && hit_ctl)   ctl_q <= wdata[NUM_BR-1:0];

  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n)             mask_q <= '1;
    else if (wr_en && hit_mask)  mask_q <= wdata[NUM_BR-1:0];

  always_ff @(posedge clk or negedge cold_rst_n)
    if (!cold_rst_n)             rdata <= '0;
    else if (!rd_en)             rdata <= '0;
    else if (hit_ctl)            rdata <= DATA_W'(ctl_q);
    else if (hit_mask)           rdata <= DATA_W'(mask_q);
    else                         rdata <= '0;

endmodule

module bridge_rst_ctl_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_BR   = 3,
  parameter int unsigned CTL_OFS  = 'h1C,
  parameter int unsigned MASK_OFS = 'h20
) (
  input logic              clk,
  input logic              cold_rst_n,
  input logic              warm_rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic [NUM_BR-1:0] bridge_rst,
  input logic [NUM_BR-1:0] mask_q
);
  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

  // R2
  write_applies_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (wr_en && addr == CTL_A && !warm_rst) |=> bridge_rst == $past(wdata[NUM_BR-1:0]));

  // R4
  warm_fill_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_rst |=> bridge_rst == ($past(bridge_rst) | $past(mask_q)));

  // R5
  mask_keep_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (warm_rst && !(wr_en && addr == MASK_A)) |=> $stable(mask_q));

  // R6
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!warm_rst && !(wr_en && addr == CTL_A)) |=> $stable(bridge_rst));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    rdata[DATA_W-1:NUM_BR] == '0);

  // R8
  undef_read_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (rd_en && addr != CTL_A && addr != MASK_A) |=> rdata == '0);

  // R3
  idle_read_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !rd_en |=> rdata == '0);
endmodule

bind bridge_rst_ctl bridge_rst_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BR(NUM_BR),
  .CTL_OFS(CTL_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst), .addr(addr),
  .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
  .bridge_rst(bridge_rst), .mask_q(mask_q)
);

// File: tb/test_bridge_rst_ctl.sv
module test_bridge_rst_ctl;
  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  bridge_rst;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [2:0]  m_ctl = 3'b111, m_mask = 3'b111;
  logic [31:0] m_rd = '0;

  always #4 clk = ~clk;

  bridge_rst_ctl i_bridge_rst_ctl (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst(warm_rst), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
    .bridge_rst(bridge_rst)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic cn, input logic wr, input logic [7:0] a,
                      input logic we, input logic [31:0] wd, input logic re, input string tag);
    logic [2:0]  n_ctl, n_mask;
    logic [31:0] n_rd;
    @(negedge clk);
    cold_rst_n = cn; warm_rst = wr; addr = a; wr_en = we; wdata = wd; rd_en = re;
    @(posedge clk);
    if (!cn) begin
      n_ctl = 3'b111; n_mask = 3'b111; n_rd = '0;
    end else begin
      n_rd = '0;
      if (re && a == 8'h1C) n_rd = {29'd0, m_ctl};
      if (re && a == 8'h20) n_rd = {29'd0, m_mask};
      n_ctl = m_ctl;
      if (wr) begin
        for (int i = 0; i < 3; i++) if (m_mask[i]) n_ctl[i] = 1'b1;
      end else if (we && a == 8'h1C) n_ctl = wd[2:0];
      n_mask = (we && a == 8'h20) ? wd[2:0] : m_mask;
    end
    m_ctl = n_ctl; m_mask = n_mask; m_rd = n_rd;
    #2;
    check(tag, "bridge_rst", {29'd0, bridge_rst}, {29'd0, m_ctl});
    check(tag, "rdata", rdata, m_rd);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(0, 0, 8'h00, 0, 0, 0, "R1");
    step(0, 1, 8'h1C, 1, 0, 0, "R9");
    step(1, 0, 8'h1C, 0, 0, 1, "R1");
    step(1, 0, 8'h20, 0, 0, 1, "R1");
    step(1, 0, 8'h1C, 1, 32'h0, 0, "R2");
    step(1, 0, 8'h1C, 1, 32'h5, 1, "R2");
    step(1, 0, 8'h1C, 0, 0, 1, "R3");
    step(1, 0, 8'h1C, 0, 0, 0, "R3");
    step(1, 0, 8'h1C, 1, 32'hFFFF_FFF8, 0, "R7");
    step(1, 0, 8'h1C, 0, 0, 1, "R7");
    step(1, 0, 8'h20, 1, 32'hFFFF_FFFA, 0, "R7");
    step(1, 0, 8'h20, 0, 0, 1, "R7");
    step(1, 1, 8'h00, 0, 0, 0, "R4");
    step(1, 0, 8'h1C, 0, 0, 1, "R4");
    step(1, 0, 8'h1C, 1, 32'h3, 0, "R2");
    step(1, 1, 8'h1C, 1, 32'h0, 0, "R6");
    step(1, 0, 8'h1C, 0, 0, 1, "R6");
    step(1, 0, 8'h20, 0, 0, 1, "R5");
    step(1, 1, 8'h20, 1, 32'h4, 0, "R5");
    step(1, 0, 8'h20, 0, 0, 1, "R5");
    step(1, 0, 8'h1C, 1, 32'h0, 0, "R2");
    step(1, 1, 8'h00, 0, 0, 0, "R4");
    step(1, 0, 8'h24, 1, 32'hFFFF_FFFF, 1, "R8");
    step(1, 0, 8'h1D, 1, 32'h0, 1, "R8");
    step(1, 0, 8'h1C, 0, 0, 1, "R8");
    step(1, 0, 8'h20, 0, 0, 1, "R8");
    step(1, 0, 8'h00, 0, 0, 0, "R6");
    step(1, 0, 8'h00, 0, 0, 0, "R6");
    step(0, 0, 8'h20, 1, 32'h0, 1, "R9");
    step(1, 0, 8'h20, 0, 0, 1, "R1");
    step(1, 0, 8'h1C, 0, 0, 1, "R1");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule